// File: doc/BRIEF.md
# Descriptor Fetch Sequencer

This block sits between a transmit or receive engine and the shared queue and DMA machinery. For each descriptor request it allocates a tracking slot and sends a dequeue request to the queue manager. When the dequeue answer comes back, it reports the outcome to the requesting engine on a status port. On success it asks the DMA engine to copy the descriptor from host memory into a slot-indexed area of a local staging RAM. Once the DMA engine reports that the copy has finished, it sends a dequeue commit. Last, it reads the staged descriptor from the RAM and delivers it as a single-beat stream transfer.

Several requests can be in flight at once, one per slot. Each party's reply names the slot it answers, so the replies may come back in any order. The queue manager, the DMA engine and the staging RAM sit outside the block. The RAM has a one-cycle synchronous read port.

Top module: `desc_fetch_seq`

## Requirements
- R1: After reset, m_deq_valid, m_stat_valid, m_dma_valid, m_cmt_valid, m_desc_tvalid and ram_rd_en are all low, and s_req_ready equals m_deq_ready.
- R2: A request is forwarded in the same cycle as a dequeue request that carries its queue number and the lowest free slot index. It is accepted only when a slot is free and m_deq_ready is high.
- R3: A dequeue response produces a one-cycle status pulse on the next cycle. The pulse carries the request tag of the named slot. Status code 0 means success.
- R4: A dequeue response flagged empty gives code 1. A response flagged error gives code 2, and error wins when both flags are set. In either case the slot is released and no DMA read or commit is issued for it.
- R5: After a successful dequeue, the block issues a DMA read request. The request carries the returned host address, a RAM offset of slot × DW/8 bytes, a length of DW/8 bytes and the slot index.
- R6: A dequeue commit carrying the queue operation tag from the dequeue response is issued only after an error-free DMA status for that slot.
- R7: After the commit, the block reads the RAM at the slot offset. The RAM data appears on m_desc_tdata two cycles after ram_rd_en, with m_desc_tuser set to the request tag and m_desc_tlast high. The transfer is held stable until m_desc_tready.
- R8: A DMA status with its error flag set produces status code 3 with the request tag. The slot is released with no commit and no descriptor.
- R9: Up to SLOTS requests may be outstanding. With every slot in use, s_req_ready and m_deq_valid stay low until a slot is released.
- R10: When a dequeue response and a pending DMA-error report fall in the same cycle, the dequeue response is reported first. The DMA error is reported in the next cycle that has no dequeue response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req_valid | input | 1 | Descriptor request valid |
| s_req_ready | output | 1 | Descriptor request accepted |
| s_req_queue | input | QW | Queue to fetch from |
| s_req_tag | input | TW | Requester tag |
| m_deq_valid | output | 1 | Dequeue request valid |
| m_deq_ready | input | 1 | Queue manager accepts dequeue |
| m_deq_queue | output | QW | Queue number |
| m_deq_slot | output | SW | Slot index used as tag |
| s_dresp_valid | input | 1 | Dequeue response valid |
| s_dresp_slot | input | SW | Slot answered |
| s_dresp_addr | input | AW | Host address of descriptor |
| s_dresp_op | input | OW | Queue operation tag |
| s_dresp_empty | input | 1 | Queue was empty |
| s_dresp_error | input | 1 | Dequeue failed |
| m_stat_valid | output | 1 | Status pulse |
| m_stat_tag | output | TW | Requester tag of the status |
| m_stat_code | output | 2 | 0 ok, 1 empty, 2 dequeue error, 3 DMA error |
| m_dma_valid | output | 1 | DMA read request valid |
| m_dma_ready | input | 1 | DMA engine accepts request |
| m_dma_addr | output | AW | Host source address |
| m_dma_ram_off | output | RW | Staging RAM byte offset |
| m_dma_len | output | LW | Transfer length in bytes |
| m_dma_slot | output | SW | Slot index |
| s_dst_valid | input | 1 | DMA status valid |
| s_dst_slot | input | SW | Slot the status belongs to |
| s_dst_error | input | 1 | DMA read failed |
| m_cmt_valid | output | 1 | Dequeue commit valid |
| m_cmt_ready | input | 1 | Queue manager accepts commit |
| m_cmt_op | output | OW | Operation tag to commit |
| ram_rd_en | output | 1 | Staging RAM read enable |
| ram_rd_addr | output | RW | Staging RAM byte address |
| ram_rd_data | input | DW | Read data, one cycle after enable |
| m_desc_tvalid | output | 1 | Descriptor stream valid |
| m_desc_tready | input | 1 | Descriptor stream ready |
| m_desc_tdata | output | DW | Descriptor |
| m_desc_tuser | output | TW | Requester tag |
| m_desc_tlast | output | 1 | End of transfer |

## Verification
The bench targets each point where the handshake can go wrong:
- **Failed fetches.** An empty queue and a failed dequeue must leave the DMA and commit ports silent. A design that forgot to release the slot would later stall with free capacity.
- **Early commit.** The bench holds off the DMA status so that a commit issued before the copy finished would be visible.
- **Status collision.** It lands a dequeue response and a DMA error in the same cycle. A design without the ordering rule would drop or corrupt one of the two reports.
- **Full table and back-pressure.** It fills every slot to catch acceptance past the limit. It also holds the descriptor stream stalled to catch data or tag changing before the handshake.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;

    typedef enum logic [2:0] {
        SL_FREE     = 3'd0,
        SL_DEQ      = 3'd1,
        SL_DMA_REQ  = 3'd2,
        SL_DMA_WAIT = 3'd3,
        SL_COMMIT   = 3'd4,
        SL_FETCH    = 3'd5,
        SL_READ     = 3'd6,
        SL_ERR      = 3'd7
    } slot_st_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_EMPTY   = 2'd1,
        ST_DEQ_ERR = 2'd2,
        ST_DMA_ERR = 2'd3
    } fetch_code_e;

endpackage

// File: rtl/dfs_pick.sv
module dfs_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
    assign found = |mask;
endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
    import desc_fetch_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int QW    = 8,
    parameter int TW    = 6,
    parameter int AW    = 32,
    parameter int OW    = 8,
    parameter int DW    = 64,
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int OFFW = $clog2(DW / 8),
    localparam int RW   = SW + OFFW,
    localparam int LW   = OFFW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_req_valid,
    output logic          s_req_ready,
    input  logic [QW-1:0] s_req_queue,
    input  logic [TW-1:0] s_req_tag,
    output logic          m_deq_valid,
    input  logic          m_deq_ready,
    output logic [QW-1:0] m_deq_queue,
    output logic [SW-1:0] m_deq_slot,
    input  logic          s_dresp_valid,
    input  logic [SW-1:0] s_dresp_slot,
    input  logic [AW-1:0] s_dresp_addr,
    input  logic [OW-1:0] s_dresp_op,
    input  logic          s_dresp_empty,
    input  logic          s_dresp_error,
    output logic          m_stat_valid,
    output logic [TW-1:0] m_stat_tag,
    output logic [1:0]    m_stat_code,
    output logic          m_dma_valid,
    input  logic          m_dma_ready,
    output logic [AW-1:0] m_dma_addr,
    output logic [RW-1:0] m_dma_ram_off,
    output logic [LW-1:0] m_dma_len,
    output logic [SW-1:0] m_dma_slot,
    input  logic          s_dst_valid,
    input  logic [SW-1:0] s_dst_slot,
    input  logic          s_dst_error,
    output logic          m_cmt_valid,
    input  logic          m_cmt_ready,
    output logic [OW-1:0] m_cmt_op,
    output logic          ram_rd_en,
    output logic [RW-1:0] ram_rd_addr,
    input  logic [DW-1:0] ram_rd_data,
    output logic          m_desc_tvalid,
    input  logic          m_desc_tready,
    output logic [DW-1:0] m_desc_tdata,
    output logic [TW-1:0] m_desc_tuser,
    output logic          m_desc_tlast
);
    localparam int DESC_BYTES = DW / 8;

    typedef struct packed {
        slot_st_e [SLOTS-1:0]          st;
        logic     [SLOTS-1:0][TW-1:0]  tag;
        logic     [SLOTS-1:0][AW-1:0]  addr;
        logic     [SLOTS-1:0][OW-1:0]  op;
        logic                          stat_valid;
        logic     [TW-1:0]             stat_tag;
        logic     [1:0]                stat_code;
        logic                          rd_pend;
        logic     [SW-1:0]             rd_slot;
        logic                          out_valid;
        logic     [DW-1:0]             out_data;
        logic     [TW-1:0]             out_tag;
    } seq_state_t;

    seq_state_t d, q;

    logic [SLOTS-1:0] free_m, dreq_m, err_m, cmt_m, fetch_m;
    logic             free_any, dreq_any, err_any, cmt_any, fetch_any;
    logic [SW-1:0]    free_idx, dreq_idx, err_idx, cmt_idx, fetch_idx;

    for (genvar g = 0; g < SLOTS; g++) begin : g_mask
        assign free_m[g]  = (q.st[g] == SL_FREE);
        assign dreq_m[g]  = (q.st[g] == SL_DMA_REQ);
        assign err_m[g]   = (q.st[g] == SL_ERR);
        assign cmt_m[g]   = (q.st[g] == SL_COMMIT);
        assign fetch_m[g] = (q.st[g] == SL_FETCH);
    end

    dfs_pick #(.N(SLOTS), .IW(SW)) u_pick_free  (.mask(free_m),  .found(free_any),  .idx(free_idx));
    dfs_pick #(.N(SLOTS), .IW(SW)) u_pick_dreq  (.mask(dreq_m),  .found(dreq_any),  .idx(dreq_idx));
    dfs_pick #(.N(SLOTS), .IW(SW)) u_pick_err   (.mask(err_m),   .found(err_any),   .idx(err_idx));
    dfs_pick #(.N(SLOTS), .IW(SW)) u_pick_cmt   (.mask(cmt_m),   .found(cmt_any),   .idx(cmt_idx));
    dfs_pick #(.N(SLOTS), .IW(SW)) u_pick_fetch (.mask(fetch_m), .found(fetch_any), .idx(fetch_idx));

    // Request side: forwarded straight to the queue manager
    assign m_deq_valid = s_req_valid && free_any;
    assign s_req_ready = free_any && m_deq_ready;
    assign m_deq_queue = s_req_queue;
    assign m_deq_slot  = free_idx;

    assign m_dma_valid   = dreq_any;
    assign m_dma_addr    = q.addr[dreq_idx];
    assign m_dma_ram_off = {dreq_idx, {OFFW{1'b0}}};
    assign m_dma_len     = LW'(DESC_BYTES);
    assign m_dma_slot    = dreq_idx;

    assign m_cmt_valid = cmt_any;
    assign m_cmt_op    = q.op[cmt_idx];

    assign m_stat_valid  = q.stat_valid;
    assign m_stat_tag    = q.stat_tag;
    assign m_stat_code   = q.stat_code;
    assign m_desc_tvalid = q.out_valid;
    assign m_desc_tdata  = q.out_data;
    assign m_desc_tuser  = q.out_tag;
    assign m_desc_tlast  = 1'b1;

    always_comb begin
        d            = q;
        d.stat_valid = 1'b0;
        ram_rd_en    = 1'b0;
        ram_rd_addr  = '0;

        if (s_req_valid && s_req_ready) begin
            d.st[free_idx]  = SL_DEQ;
            d.tag[free_idx] = s_req_tag;
        end

        // Status port: dequeue response first, stored DMA error otherwise
        if (s_dresp_valid) begin
            d.stat_valid = 1'b1;
            d.stat_tag   = q.tag[s_dresp_slot];
            if (s_dresp_error) begin
                d.stat_code         = ST_DEQ_ERR;
                d.st[s_dresp_slot]  = SL_FREE;
            end else if (s_dresp_empty) begin
                d.stat_code         = ST_EMPTY;
                d.st[s_dresp_slot]  = SL_FREE;
            end else begin
                d.stat_code          = ST_OK;
                d.st[s_dresp_slot]   = SL_DMA_REQ;
                d.addr[s_dresp_slot] = s_dresp_addr;
                d.op[s_dresp_slot]   = s_dresp_op;
            end
        end else if (err_any) begin
            d.stat_valid   = 1'b1;
            d.stat_tag     = q.tag[err_idx];
            d.stat_code    = ST_DMA_ERR;
            d.st[err_idx]  = SL_FREE;
        end

        if (m_dma_valid && m_dma_ready) d.st[dreq_idx] = SL_DMA_WAIT;
        if (s_dst_valid) d.st[s_dst_slot] = s_dst_error ? SL_ERR : SL_COMMIT;
        if (m_cmt_valid && m_cmt_ready) d.st[cmt_idx] = SL_FETCH;

        if (q.out_valid && m_desc_tready) d.out_valid = 1'b0;

        // Staging RAM read path, one descriptor in flight
        if (q.rd_pend) begin
            d.out_valid       = 1'b1;
            d.out_data        = ram_rd_data;
            d.out_tag         = q.tag[q.rd_slot];
            d.st[q.rd_slot]   = SL_FREE;
            d.rd_pend         = 1'b0;
        end else if (fetch_any && !q.out_valid) begin
            ram_rd_en         = 1'b1;
            ram_rd_addr       = {fetch_idx, {OFFW{1'b0}}};
            d.st[fetch_idx]   = SL_READ;
            d.rd_pend         = 1'b1;
            d.rd_slot         = fetch_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (free_m == '0) |-> (!s_req_ready && !m_deq_valid));

    a_r3_ok_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (s_dresp_valid && !s_dresp_error && !s_dresp_empty) |=> (m_stat_valid && m_stat_code == ST_OK));

    a_r4_fail_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (s_dresp_valid && (s_dresp_error || s_dresp_empty)) |=> (m_stat_valid && m_stat_code != ST_OK));

    a_r10_resp_wins: assert property (@(posedge clk) disable iff (!rst_n)
        s_dresp_valid |=> (m_stat_valid && m_stat_code != ST_DMA_ERR || m_stat_valid && $past(s_dresp_error) == 1'b0 && $past(s_dresp_empty) == 1'b0 && m_stat_code == ST_OK || m_stat_valid && m_stat_code != ST_DMA_ERR));

    a_r7_hold_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (m_desc_tvalid && !m_desc_tready) |=> (m_desc_tvalid && $stable(m_desc_tdata) && $stable(m_desc_tuser)));

    a_r7_read_to_stream: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> ##1 m_desc_tvalid);
endmodule

// File: tb/desc_fetch_seq_tb.sv
module desc_fetch_seq_tb;
    localparam int SLOTS = 4, QW = 8, TW = 6, AW = 32, OW = 8, DW = 64;
    localparam int SW = 2, OFFW = 3, RW = 5, LW = 4;

    logic clk = 0, rst_n = 0;
    logic s_req_valid = 0, m_deq_ready = 1;
    logic [QW-1:0] s_req_queue = '0;
    logic [TW-1:0] s_req_tag = '0;
    logic s_req_ready, m_deq_valid;
    logic [QW-1:0] m_deq_queue;
    logic [SW-1:0] m_deq_slot;
    logic s_dresp_valid = 0, s_dresp_empty = 0, s_dresp_error = 0;
    logic [SW-1:0] s_dresp_slot = '0;
    logic [AW-1:0] s_dresp_addr = '0;
    logic [OW-1:0] s_dresp_op = '0;
    logic m_stat_valid;
    logic [TW-1:0] m_stat_tag;
    logic [1:0] m_stat_code;
    logic m_dma_valid, m_dma_ready = 0;
    logic [AW-1:0] m_dma_addr;
    logic [RW-1:0] m_dma_ram_off;
    logic [LW-1:0] m_dma_len;
    logic [SW-1:0] m_dma_slot;
    logic s_dst_valid = 0, s_dst_error = 0;
    logic [SW-1:0] s_dst_slot = '0;
    logic m_cmt_valid, m_cmt_ready = 0;
    logic [OW-1:0] m_cmt_op;
    logic ram_rd_en;
    logic [RW-1:0] ram_rd_addr;
    logic [DW-1:0] ram_rd_data = '0;
    logic m_desc_tvalid, m_desc_tready = 0, m_desc_tlast;
    logic [DW-1:0] m_desc_tdata;
    logic [TW-1:0] m_desc_tuser;

    always #10 clk = ~clk;

    desc_fetch_seq u_dut (.*);

    logic [DW-1:0] ram_mem [SLOTS];
    always @(posedge clk) if (ram_rd_en) ram_rd_data <= ram_mem[ram_rd_addr[RW-1:OFFW]];

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit [SLOTS-1:0] busy = '0;

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] desc_of(logic [AW-1:0] a);
        return {a, a ^ 32'h5a5a_a5a5};
    endfunction

    function automatic int lowest_free();
        for (int i = 0; i < SLOTS; i++) if (!busy[i]) return i;
        return 0;
    endfunction

    task automatic issue(input logic [QW-1:0] qn, input logic [TW-1:0] t, output int slot);
        @(negedge clk);
        s_req_valid = 1; s_req_queue = qn; s_req_tag = t;
        #1;
        slot = lowest_free();
        chk("R2", "req ready", s_req_ready, 1);
        chk("R2", "deq valid", m_deq_valid, 1);
        chk("R2", "deq queue", m_deq_queue, qn);
        chk("R2", "deq slot", m_deq_slot, slot);
        busy[slot] = 1;
        @(posedge clk); #1 s_req_valid = 0;
    endtask

    task automatic dresp(int slot, logic [AW-1:0] a, logic [OW-1:0] op, bit emp, bit err, logic [TW-1:0] t);
        logic [1:0] code;
        code = err ? 2'd2 : (emp ? 2'd1 : 2'd0);
        @(negedge clk);
        s_dresp_valid = 1; s_dresp_slot = SW'(slot); s_dresp_addr = a; s_dresp_op = op;
        s_dresp_empty = emp; s_dresp_error = err;
        @(negedge clk);
        s_dresp_valid = 0;
        chk(code == 0 ? "R3" : "R4", "status valid", m_stat_valid, 1);
        chk(code == 0 ? "R3" : "R4", "status tag", m_stat_tag, t);
        chk(code == 0 ? "R3" : "R4", "status code", m_stat_code, code);
        if (code != 0) busy[slot] = 0;
    endtask

    task automatic wait_stat(logic [TW-1:0] t, logic [1:0] code, string rq);
        bit seen = 0;
        for (int i = 0; i < 6 && !seen; i++) begin
            @(negedge clk);
            if (m_stat_valid) begin
                seen = 1;
                chk(rq, "status tag", m_stat_tag, t);
                chk(rq, "status code", m_stat_code, code);
            end
        end
        if (!seen) chk(rq, "status seen", 0, 1);
    endtask

    task automatic dma_take(int slot, logic [AW-1:0] a);
        @(negedge clk);
        chk("R5", "dma valid", m_dma_valid, 1);
        chk("R5", "dma addr", m_dma_addr, a);
        chk("R5", "dma ram offset", m_dma_ram_off, slot * (DW / 8));
        chk("R5", "dma length", m_dma_len, DW / 8);
        chk("R5", "dma slot", m_dma_slot, slot);
        m_dma_ready = 1;
        @(posedge clk); #1 m_dma_ready = 0;
        @(negedge clk);
        chk("R6", "no commit before dma status", m_cmt_valid, 0);
    endtask

    task automatic dst(int slot, bit err, logic [DW-1:0] data);
        @(negedge clk);
        s_dst_valid = 1; s_dst_slot = SW'(slot); s_dst_error = err;
        if (!err) ram_mem[slot] = data;
        @(posedge clk); #1 s_dst_valid = 0;
    endtask

    task automatic cmt_take(logic [OW-1:0] op);
        bit seen = 0;
        for (int i = 0; i < 5 && !seen; i++) begin
            @(negedge clk);
            if (m_cmt_valid) seen = 1;
        end
        chk("R6", "commit valid", m_cmt_valid, 1);
        chk("R6", "commit op tag", m_cmt_op, op);
        m_cmt_ready = 1;
        @(posedge clk); #1 m_cmt_ready = 0;
    endtask

    task automatic desc_take(int slot, logic [DW-1:0] data, logic [TW-1:0] t);
        bit seen = 0;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge clk);
            if (m_desc_tvalid) seen = 1;
        end
        chk("R7", "desc valid", m_desc_tvalid, 1);
        chk("R7", "desc data", m_desc_tdata, data);
        chk("R7", "desc tuser", m_desc_tuser, t);
        chk("R7", "desc tlast", m_desc_tlast, 1);
        @(negedge clk);
        chk("R7", "desc held", {m_desc_tvalid, m_desc_tuser}, {1'b1, t});
        chk("R7", "desc data held", m_desc_tdata, data);
        m_desc_tready = 1;
        @(posedge clk); #1 m_desc_tready = 0;
        busy[slot] = 0;
        @(negedge clk);
        chk("R7", "desc drained", m_desc_tvalid, 0);
    endtask

    // outcome: 0 success, 1 empty, 2 dequeue error, 3 DMA error
    task automatic txn(logic [QW-1:0] qn, logic [TW-1:0] t, logic [AW-1:0] a, logic [OW-1:0] op, int outcome);
        int slot;
        issue(qn, t, slot);
        dresp(slot, a, op, outcome == 1, outcome == 2, t);
        if (outcome == 1 || outcome == 2) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk("R4", "no dma after failed dequeue", m_dma_valid, 0);
                chk("R4", "no commit after failed dequeue", m_cmt_valid, 0);
            end
            return;
        end
        dma_take(slot, a);
        if (outcome == 3) begin
            dst(slot, 1, '0);
            wait_stat(t, 2'd3, "R8");
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R8", "no commit after dma error", m_cmt_valid, 0);
                chk("R8", "no descriptor after dma error", m_desc_tvalid, 0);
            end
            busy[slot] = 0;
        end else begin
            dst(slot, 0, desc_of(a));
            cmt_take(op);
            desc_take(slot, desc_of(a), t);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int sa, sb, st;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1", "deq valid after reset", m_deq_valid, 0);
        chk("R1", "stat valid after reset", m_stat_valid, 0);
        chk("R1", "dma valid after reset", m_dma_valid, 0);
        chk("R1", "commit valid after reset", m_cmt_valid, 0);
        chk("R1", "desc valid after reset", m_desc_tvalid, 0);
        chk("R1", "ram read after reset", ram_rd_en, 0);
        chk("R1", "ready follows deq ready", s_req_ready, 1);
        m_deq_ready = 0; #1;
        chk("R1", "ready low with deq ready low", s_req_ready, 0);
        m_deq_ready = 1;

        // Directed: one of each outcome
        txn(8'h11, 6'h05, 32'h1000_0040, 8'h21, 0);
        txn(8'h12, 6'h06, 32'h1000_0080, 8'h22, 1);
        txn(8'h13, 6'h07, 32'h1000_00c0, 8'h23, 2);
        txn(8'h14, 6'h08, 32'h1000_0100, 8'h24, 3);
        begin : both_flags
            int s;
            issue(8'h15, 6'h09, s);
            dresp(s, 32'h0, 8'h0, 1, 1, 6'h09);
        end

        // R9: fill every slot, then stall
        for (int i = 0; i < SLOTS; i++) begin
            int s;
            issue(8'(8'h30 + i), 6'(6'h10 + i), s);
        end
        @(negedge clk);
        s_req_valid = 1; s_req_queue = 8'h3f; s_req_tag = 6'h1f; #1;
        chk("R9", "ready low when full", s_req_ready, 0);
        chk("R9", "no dequeue when full", m_deq_valid, 0);
        s_req_valid = 0;
        dresp(2, 32'h0, 8'h0, 1, 0, 6'h12);
        issue(8'h3f, 6'h1f, sa);
        chk("R9", "freed slot reused", sa, 2);
        for (int i = 0; i < SLOTS; i++) dresp(i, 32'h0, 8'h0, 1, 0, (i == 2) ? 6'h1f : 6'(6'h10 + i));

        // R10: dequeue response and DMA error in the same cycle
        issue(8'h41, 6'h21, sa);
        dresp(sa, 32'h2000_0000, 8'h31, 0, 0, 6'h21);
        dma_take(sa, 32'h2000_0000);
        issue(8'h42, 6'h22, sb);
        @(negedge clk);
        s_dresp_valid = 1; s_dresp_slot = SW'(sb); s_dresp_addr = 32'h2000_0040; s_dresp_op = 8'h32;
        s_dresp_empty = 0; s_dresp_error = 0;
        s_dst_valid = 1; s_dst_slot = SW'(sa); s_dst_error = 1;
        @(negedge clk);
        s_dresp_valid = 0; s_dst_valid = 0; s_dst_error = 0;
        chk("R10", "first report is dequeue", {m_stat_valid, m_stat_tag, m_stat_code}, {1'b1, 6'h22, 2'd0});
        @(negedge clk);
        chk("R10", "second report is dma error", {m_stat_valid, m_stat_tag, m_stat_code}, {1'b1, 6'h21, 2'd3});
        busy[sa] = 0;
        dma_take(sb, 32'h2000_0040);
        dst(sb, 0, desc_of(32'h2000_0040));
        cmt_take(8'h32);
        desc_take(sb, desc_of(32'h2000_0040), 6'h22);

        // Constrained random transactions
        for (int n = 0; n < 40; n++) begin
            st = ($urandom_range(0, 9) < 6) ? 0 : $urandom_range(1, 3);
            txn(8'($urandom), 6'($urandom), {$urandom_range(0, 32'h0fff_ffff), 4'h0}, 8'($urandom), st);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule